// File: doc/BRIEF.md
# Edge-Triggered Interrupt Vector Arbiter

This block sits between four active-low trigger pins and a playback sequencer. Each pin idles high. Its level is synchronised and then filtered: a change counts only when the new level has held for a full debounce window. One mode bit selects a short or a long window, both counted in prescaler ticks. Every qualified edge is gated by its own enable bit, taken from one of two 8-bit enable words. If the bit is set, the edge raises a pending request.

Two other sources compete with the pin edges. The first is a power-on request, which fires once a fixed number of ticks after reset. The second is a software jump request, which carries its own target vector. The block grants one pending request at a time, in fixed priority order. For each grant it emits a vector number with a one-cycle valid strobe, and it clears the pending flag it granted.

Top module: `trig_vec_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, `irq_vld_o` is 0.
- R2: Exactly `POI_TICKS` ticks after reset, the block grants vector 32 exactly once.
- R3: With `deb_long_i` = 0, a pin level change shorter than `DEB_SHORT` ticks produces no vector. A level held longer produces one vector.
- R4: With `deb_long_i` = 1, a level change held longer than `DEB_SHORT` ticks but shorter than `DEB_LONG` ticks produces no vector. One held longer than `DEB_LONG` ticks produces one vector.
- R5: A qualified falling edge on `trig_n_i[0]`, `[1]`, `[2]` or `[3]` yields vector 0, 1, 8 or 9 respectively.
- R6: A qualified rising edge on `trig_n_i[0]`, `[1]`, `[2]` or `[3]` yields vector 4, 5, 12 or 13 respectively.
- R7: Enable bits are assigned as follows:
  - `en_lo_i` bit 0 gates the pin 0 falling edge, bit 1 the pin 1 falling edge, bit 4 the pin 0 rising edge, and bit 5 the pin 1 rising edge.
  - `en_hi_i` uses the same positions for pins 2 and 3.
  - All other bits are ignored.
  - An edge whose bit is 0 produces no vector.
- R8: When several requests are pending, they are granted from highest to lowest priority in this order: power-on, pin0 fall, pin0 rise, pin1 fall, pin1 rise, pin2 fall, pin2 rise, pin3 fall, pin3 rise, jump.
- R9: A one-cycle `jmp_req_i` pulse yields vector `jmp_vec_i` once. The jump is granted only after every pending pin edge.
- R10: `irq_vld_o` is high for single cycles only and is never high in two consecutive cycles.
- R11: A pending request is cleared when granted. Each qualified event yields exactly one vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_n_i | input | 4 | Raw active-low trigger pins, idle high |
| en_lo_i | input | 8 | Edge enable word for pins 0 and 1 |
| en_hi_i | input | 8 | Edge enable word for pins 2 and 3 |
| deb_long_i | input | 1 | 1 selects the long debounce window, 0 the short one |
| jmp_req_i | input | 1 | Software jump request pulse |
| jmp_vec_i | input | 6 | Target vector of the jump request |
| irq_vld_o | output | 1 | One-cycle grant strobe |
| irq_vec_o | output | 6 | Granted vector number |

## Verification
The hardest situation to reach is having several sources pending at once. The debounce filter spreads pin events over time, so a stray change on one pin never lines up with another. The bench therefore switches several pins in the same cycle. Because they share one tick, their debounce windows all complete together, and the resulting edges land in the pending register at the same time.

A jump is injected at the moment the first grant of such a burst appears. This leaves the jump queued behind the remaining edges. Driving one pin rising while another falls in the same cycle checks the ordering across pins.

// File: rtl/trig_arb_pkg.sv
package trig_arb_pkg;

    localparam int NUM_PINS  = 4;
    localparam int NUM_EDGES = 2 * NUM_PINS;
    localparam int VEC_W     = 6;

    localparam logic [VEC_W-1:0] POWERON_VEC = 6'd32;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_POWERON = 2'd1,
        SRC_EDGE = 2'd2,
        SRC_JUMP = 2'd3
    } src_kind_t;

    typedef struct packed {
        src_kind_t          kind;
        logic [VEC_W-1:0]   vec;
    } grant_t;

    // Edge slot index: 2*pin + (1 for rising). Vector = (pin%2) + 8*(pin/2) + 4*rising.
    function automatic logic [VEC_W-1:0] slot_vector(input int unsigned slot);
        int unsigned pin;
        int unsigned v;
        pin = slot >> 1;
        v   = (pin & 1) + ((pin >> 1) * 8) + ((slot & 1) * 4);
        return VEC_W'(v);
    endfunction

    // Bit position of an edge enable inside its enable word.
    function automatic int unsigned enable_pos(input int unsigned pin, input logic rising);
        return (pin & 1) + (rising ? 4 : 0);
    endfunction

endpackage

// File: rtl/trig_tick_gen.sv
module trig_tick_gen #(
    parameter int TICK_DIV = 250
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CW = $clog2(TICK_DIV + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q == CW'(TICK_DIV - 1)) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end

endmodule

// File: rtl/trig_debounce.sv
module trig_debounce #(
    parameter int DEB_SHORT = 400,
    parameter int DEB_LONG  = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic long_i,
    input  logic pin_n_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = $clog2(DEB_LONG + 1);

    logic          sync1_q, sync2_q;
    logic          lvl_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    assign limit = long_i ? CW'(DEB_LONG - 1) : CW'(DEB_SHORT - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
        end else begin
            sync1_q <= pin_n_i;
            sync2_q <= sync1_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= 1'b1;
            cnt_q  <= '0;
            rise_o <= 1'b0;
            fall_o <= 1'b0;
        end else begin
            rise_o <= 1'b0;
            fall_o <= 1'b0;
            if (sync2_q == lvl_q) begin
                cnt_q <= '0;
            end else if (tick_i) begin
                if (cnt_q >= limit) begin
                    lvl_q  <= sync2_q;
                    cnt_q  <= '0;
                    rise_o <= sync2_q;
                    fall_o <= ~sync2_q;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    AST_LVL_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (lvl_q != $past(lvl_q)) |-> $past(tick_i)) else $error("level moved off tick"); // R3

    AST_EDGE_MATCHES_LVL: assert property (@(posedge clk) disable iff (rst)
        rise_o |-> lvl_q) else $error("rise without high level"); // R6

endmodule

// File: rtl/trig_pend_arb.sv
module trig_pend_arb
    import trig_arb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PINS-1:0]  rise_i,
    input  logic [NUM_PINS-1:0]  fall_i,
    input  logic [7:0]           en_lo_i,
    input  logic [7:0]           en_hi_i,
    input  logic                 poweron_i,
    input  logic                 jmp_req_i,
    input  logic [VEC_W-1:0]     jmp_vec_i,
    output logic                 vld_o,
    output logic [VEC_W-1:0]     vec_o
);
    logic [NUM_EDGES-1:0] set_vec;
    logic [NUM_EDGES-1:0] pend_q;
    logic [NUM_EDGES-1:0] gnt_hot;
    logic                 poweron_q;
    logic                 jmp_q;
    logic [VEC_W-1:0]     jmp_vec_q;
    logic                 grant_ok;
    logic                 edge_hit;
    int unsigned          edge_idx;
    grant_t               win;

    genvar p;
    generate
        for (p = 0; p < NUM_PINS; p++) begin : g_pin
            logic [7:0] en_word;
            if (p < 2) begin : g_lo
                assign en_word = en_lo_i;
            end else begin : g_hi
                assign en_word = en_hi_i;
            end
            assign set_vec[2*p]   = fall_i[p] & en_word[enable_pos(p, 1'b0)];
            assign set_vec[2*p+1] = rise_i[p] & en_word[enable_pos(p, 1'b1)];
        end
    endgenerate

    logic unused_en;
    assign unused_en = ^{en_lo_i[7:6], en_lo_i[3:2], en_hi_i[7:6], en_hi_i[3:2]};

    assign grant_ok = ~vld_o;

    always_comb begin
        edge_hit = 1'b0;
        edge_idx = 0;
        for (int i = NUM_EDGES - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                edge_hit = 1'b1;
                edge_idx = i;
            end
        end
    end

    always_comb begin
        win.kind = SRC_NONE;
        win.vec  = '0;
        if (poweron_q) begin
            win.kind = SRC_POWERON;
            win.vec  = POWERON_VEC;
        end else if (edge_hit) begin
            win.kind = SRC_EDGE;
            win.vec  = slot_vector(edge_idx);
        end else if (jmp_q) begin
            win.kind = SRC_JUMP;
            win.vec  = jmp_vec_q;
        end
    end

    always_comb begin
        gnt_hot = '0;
        if (grant_ok && win.kind == SRC_EDGE) begin
            gnt_hot[edge_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= '0;
            poweron_q <= 1'b0;
            jmp_q     <= 1'b0;
            jmp_vec_q <= '0;
            vld_o     <= 1'b0;
            vec_o     <= '0;
        end else begin
            pend_q <= (pend_q & ~gnt_hot) | set_vec;

            if (poweron_i) begin
                poweron_q <= 1'b1;
            end else if (grant_ok && win.kind == SRC_POWERON) begin
                poweron_q <= 1'b0;
            end

            if (jmp_req_i) begin
                jmp_q     <= 1'b1;
                jmp_vec_q <= jmp_vec_i;
            end else if (grant_ok && win.kind == SRC_JUMP) begin
                jmp_q <= 1'b0;
            end

            vld_o <= grant_ok && (win.kind != SRC_NONE);
            if (grant_ok && win.kind != SRC_NONE) begin
                vec_o <= win.vec;
            end
        end
    end

    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
        vld_o |=> !vld_o) else $error("valid held two cycles"); // R10

    generate
        for (p = 0; p < NUM_EDGES; p++) begin : g_chk
            AST_CLEAR_ON_GRANT: assert property (@(posedge clk) disable iff (rst)
                (gnt_hot[p] && !set_vec[p]) |=> !pend_q[p]) else $error("pending not cleared"); // R11

            AST_PEND_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
                $rose(pend_q[p]) |-> $past(set_vec[p])) else $error("pending set without enabled edge"); // R7
        end
    endgenerate

    AST_JUMP_LAST: assert property (@(posedge clk) disable iff (rst)
        (grant_ok && win.kind == SRC_JUMP) |-> (pend_q == '0 && !poweron_q)) else $error("jump passed an edge"); // R9

endmodule

// File: rtl/trig_vec_arbiter.sv
module trig_vec_arbiter
    import trig_arb_pkg::*;
#(
    parameter int TICK_DIV  = 250,
    parameter int DEB_SHORT = 400,
    parameter int DEB_LONG  = 50000,
    parameter int POI_TICKS = 160000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        trig_n_i,
    input  logic [7:0]        en_lo_i,
    input  logic [7:0]        en_hi_i,
    input  logic              deb_long_i,
    input  logic              jmp_req_i,
    input  logic [5:0]        jmp_vec_i,
    output logic              irq_vld_o,
    output logic [5:0]        irq_vec_o
);
    localparam int PW = $clog2(POI_TICKS + 1);

    logic                tick;
    logic [NUM_PINS-1:0] rise;
    logic [NUM_PINS-1:0] fall;
    logic [PW-1:0]       poi_cnt_q;
    logic                poi_done_q;
    logic                poi_fire_q;

    trig_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    genvar p;
    generate
        for (p = 0; p < NUM_PINS; p++) begin : g_deb
            trig_debounce #(.DEB_SHORT(DEB_SHORT), .DEB_LONG(DEB_LONG)) u_deb (
                .clk     (clk),
                .rst     (rst),
                .tick_i  (tick),
                .long_i  (deb_long_i),
                .pin_n_i (trig_n_i[p]),
                .rise_o  (rise[p]),
                .fall_o  (fall[p])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            poi_cnt_q  <= '0;
            poi_done_q <= 1'b0;
            poi_fire_q <= 1'b0;
        end else begin
            poi_fire_q <= 1'b0;
            if (!poi_done_q && tick) begin
                if (poi_cnt_q == PW'(POI_TICKS - 1)) begin
                    poi_done_q <= 1'b1;
                    poi_fire_q <= 1'b1;
                end else begin
                    poi_cnt_q <= poi_cnt_q + 1'b1;
                end
            end
        end
    end

    trig_pend_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .rise_i    (rise),
        .fall_i    (fall),
        .en_lo_i   (en_lo_i),
        .en_hi_i   (en_hi_i),
        .poweron_i (poi_fire_q),
        .jmp_req_i (jmp_req_i),
        .jmp_vec_i (jmp_vec_i),
        .vld_o     (irq_vld_o),
        .vec_o     (irq_vec_o)
    );

    AST_POI_ONCE: assert property (@(posedge clk) disable iff (rst)
        poi_done_q |-> !poi_fire_q || $rose(poi_done_q) || $past(!poi_done_q)) else $error("power-on fired twice"); // R2

    AST_POI_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(poi_done_q) |-> poi_done_q) else $error("power-on flag dropped"); // R2

endmodule

// File: tb/trig_vec_arbiter_bench.sv
module trig_vec_arbiter_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] trig_n;
    logic [7:0] en_lo, en_hi;
    logic       deb_long;
    logic       jmp_req;
    logic [5:0] jmp_vec;
    logic       irq_vld;
    logic [5:0] irq_vec;

    int checks = 0;
    int failures = 0;
    int exp_q[$];
    string tag_q[$];
    logic prev_vld = 1'b0;

    always #2 clk = ~clk;

    trig_vec_arbiter #(.TICK_DIV(2), .DEB_SHORT(4), .DEB_LONG(12), .POI_TICKS(20)) u_trig_vec_arbiter (
        .clk        (clk),
        .rst        (rst),
        .trig_n_i   (trig_n),
        .en_lo_i    (en_lo),
        .en_hi_i    (en_hi),
        .deb_long_i (deb_long),
        .jmp_req_i  (jmp_req),
        .jmp_vec_i  (jmp_vec),
        .irq_vld_o  (irq_vld),
        .irq_vec_o  (irq_vec)
    );

    task automatic expect_vec(input int v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_drained(input string tag);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL %s pending expectations actual=%0d expected=0", tag, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    // Monitor: scoreboard compare and strobe width.
    always @(negedge clk) begin
        if (!rst) begin
            if (irq_vld && prev_vld) begin
                checks++;
                failures++;
                $display("FAIL R10 valid high two cycles actual=1 expected=0");
            end
            if (irq_vld) begin
                checks++;
                if (exp_q.size() == 0) begin
                    failures++;
                    $display("FAIL R11 unexpected vector actual=%0d expected=none", irq_vec);
                end else begin
                    int e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (int'(irq_vec) != e) begin
                        failures++;
                        $display("FAIL %s vector actual=%0d expected=%0d", t, irq_vec, e);
                    end
                end
            end
        end
        prev_vld = irq_vld;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R10 watchdog expired actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; trig_n = 4'hF; en_lo = 8'h33; en_hi = 8'h33;
        deb_long = 1'b0; jmp_req = 1'b0; jmp_vec = '0;
        idle(5);
        checks++;
        if (irq_vld !== 1'b0) begin
            failures++;
            $display("FAIL R1 valid in reset actual=%0b expected=0", irq_vld);
        end
        expect_vec(32, "R2");
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (irq_vld !== 1'b0) begin
            failures++;
            $display("FAIL R1 valid after reset actual=%0b expected=0", irq_vld);
        end
        idle(100);
        check_drained("R2");

        // R5 / R6: each pin alone
        for (int p = 0; p < 4; p++) begin
            int fv;
            fv = (p % 2) + 8 * (p / 2);
            expect_vec(fv, "R5");
            trig_n[p] = 1'b0;
            idle(30);
            expect_vec(fv + 4, "R6");
            trig_n[p] = 1'b1;
            idle(30);
        end
        check_drained("R5");

        // R3: short glitch ignored
        trig_n[0] = 1'b0; idle(3); trig_n[0] = 1'b1;
        idle(30);
        check_drained("R3");

        // R8: simultaneous edges on all pins
        expect_vec(0, "R8"); expect_vec(1, "R8"); expect_vec(8, "R8"); expect_vec(9, "R8");
        trig_n = 4'h0; idle(40);
        expect_vec(4, "R8"); expect_vec(5, "R8"); expect_vec(12, "R8"); expect_vec(13, "R8");
        trig_n = 4'hF; idle(40);
        check_drained("R8");

        // R8: pin0 rising ahead of pin1 falling
        expect_vec(0, "R8"); trig_n[0] = 1'b0; idle(30);
        expect_vec(4, "R8"); expect_vec(1, "R8");
        trig_n[0] = 1'b1; trig_n[1] = 1'b0; idle(30);
        expect_vec(5, "R8"); trig_n[1] = 1'b1; idle(30);
        check_drained("R8");

        // R9: jump queued behind pending edges
        expect_vec(0, "R9"); expect_vec(1, "R9"); expect_vec(8, "R9"); expect_vec(9, "R9");
        trig_n = 4'h0;
        while (irq_vld !== 1'b1) @(negedge clk);
        jmp_req = 1'b1; jmp_vec = 6'd40; expect_vec(40, "R9");
        @(negedge clk); jmp_req = 1'b0;
        idle(30);
        expect_vec(4, "R9"); expect_vec(5, "R9"); expect_vec(12, "R9"); expect_vec(13, "R9");
        trig_n = 4'hF; idle(40);
        expect_vec(17, "R9");
        jmp_req = 1'b1; jmp_vec = 6'd17; @(negedge clk); jmp_req = 1'b0;
        idle(10);
        check_drained("R9");

        // R7: enable gating, don't-care bits set
        en_lo = 8'hCC;
        trig_n[0] = 1'b0; idle(30); trig_n[0] = 1'b1; idle(30);
        check_drained("R7");
        en_lo = 8'h10; en_hi = 8'h02;
        expect_vec(4, "R7");
        trig_n[0] = 1'b0; idle(30); trig_n[0] = 1'b1; idle(30);
        expect_vec(9, "R7");
        trig_n[3] = 1'b0; idle(30); trig_n[3] = 1'b1; idle(30);
        check_drained("R7");
        en_lo = 8'h33; en_hi = 8'h33;

        // R4: long debounce window
        deb_long = 1'b1;
        trig_n[1] = 1'b0; idle(16); trig_n[1] = 1'b1; idle(60);
        check_drained("R4");
        expect_vec(1, "R4");
        trig_n[1] = 1'b0; idle(60);
        expect_vec(5, "R4");
        trig_n[1] = 1'b1; idle(60);
        check_drained("R4");

        idle(20);
        check_drained("R11");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule